// File: doc/BRIEF.md
# Banked Internal Data RAM

This block is the 128-byte on-chip data store of an 8-bit microcontroller core. The same storage can be reached three ways. A byte port reads and writes any byte by its absolute address. A register port reads working register R0 to R7 of the currently active register bank. A bit port reads or writes one bit of a sixteen-byte window through a 7-bit bit address.

The low 32 bytes hold four banks of eight registers. The active bank is held in a small register that software loads through the bank port, and reset returns it to bank 0. The bytes starting at 20H form the bit window. The bytes from 30H up are ordinary scratch storage. Reads are combinational from the current contents. Writes land on the rising clock edge. A bit write is a read-modify-write of its byte that completes in one clock.

Top module: `iram_banked`

## Requirements
- R1: Any of the 128 bytes (00H to 7FH) can be written through the byte port on a rising edge while `byte_we_i` is high, and `byte_rdata_o` shows the current contents of `byte_addr_i` combinationally.
- R2: `reg_rdata_o` shows byte `bank*8 + reg_idx_i`: the bank number forms address bits [4:3] and the register index forms bits [2:0].
- R3: On a rising edge with `bank_wr_i` high, the active bank is loaded from `bank_sel_i`. Register reads use the new bank from the following cycle.
- R4: Reset sets the active bank to 0 and leaves the RAM contents unchanged.
- R5: Bit address k reads bit position (k mod 8) of byte 20H + (k div 8), so bits 00H to 7FH cover bytes 20H to 2FH, and `bit_rdata_o` shows that bit.
- R6: A bit write with `bit_we_i` high sets the addressed bit to `bit_val_i` on the next rising edge and leaves the other seven bits of that byte unchanged.
- R7: When the byte port writes the same byte that a bit write targets in the same cycle, the byte write decides the whole byte and the bit write is dropped.
- R8: A byte write and a bit write to different bytes in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the bank register |
| bank_wr_i | input | 1 | Load the active bank |
| bank_sel_i | input | 2 | Bank number to load |
| byte_addr_i | input | 7 | Byte port address |
| byte_we_i | input | 1 | Byte port write enable |
| byte_wdata_i | input | 8 | Byte port write data |
| byte_rdata_o | output | 8 | Byte port read data |
| reg_idx_i | input | 3 | Register index within active bank |
| reg_rdata_o | output | 8 | Register port read data |
| bit_addr_i | input | 7 | Bit address into the bit window |
| bit_we_i | input | 1 | Bit write enable |
| bit_val_i | input | 1 | Bit value to write |
| bit_rdata_o | output | 1 | Addressed bit |

## Verification
The bench builds the block with its default parameters: 128 bytes, four banks of eight registers, and a sixteen-byte bit window at 20H. With these values the whole address space, every bank and all 128 bit addresses can be reached within a short seeded random run. A quarter of the random cycles aim the byte port at the byte that the bit port targets, so the same-byte clash and the different-byte dual write both occur many times. The end bit addresses 00H and 7FH, a mid-run reset with a non-zero bank loaded, and a bank change followed by an immediate register read are driven as directed cases.

// File: rtl/iram_pkg.sv
package iram_pkg;
  // Absolute byte address of a working register.
  function automatic int unsigned reg_byte_of(input int unsigned bank,
                                              input int unsigned idx,
                                              input int unsigned regs);
    return bank * regs + idx;
  endfunction

  // Byte holding a given bit of the bit window.
  function automatic int unsigned bit_byte_of(input int unsigned k,
                                              input int unsigned base,
                                              input int unsigned dw);
    return base + k / dw;
  endfunction

  // Position of a given bit inside its byte.
  function automatic int unsigned bit_pos_of(input int unsigned k,
                                             input int unsigned dw);
    return k % dw;
  endfunction
endpackage

// File: rtl/iram_bank.sv
module iram_bank #(
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [BANK_W-1:0] sel_i,
  output logic [BANK_W-1:0] bank_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bank_o <= '0;
    else if (load_i) bank_o <= sel_i;
  end
endmodule

// File: rtl/iram_map.sv
module iram_map #(
  parameter int AW        = 7,
  parameter int BANK_W    = 2,
  parameter int IDX_W     = 3,
  parameter int BIT_AW    = 7,
  parameter int POS_W     = 3,
  parameter int BANK_REGS = 8,
  parameter int BIT_BASE  = 32,
  parameter int DATA_W    = 8
) (
  input  logic [BANK_W-1:0] bank_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [BIT_AW-1:0] bit_addr_i,
  output logic [AW-1:0]     reg_addr_o,
  output logic [AW-1:0]     bit_byte_o,
  output logic [POS_W-1:0]  bit_pos_o
);
  always_comb begin
    reg_addr_o = AW'(iram_pkg::reg_byte_of(32'(bank_i), 32'(idx_i), BANK_REGS));
    bit_byte_o = AW'(iram_pkg::bit_byte_of(32'(bit_addr_i), BIT_BASE, DATA_W));
    bit_pos_o  = POS_W'(iram_pkg::bit_pos_of(32'(bit_addr_i), DATA_W));
  end
endmodule

// File: rtl/iram_store.sv
module iram_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 128,
  parameter int AW     = 7,
  parameter int POS_W  = 3
) (
  input  logic              clk,
  input  logic              byte_we_i,
  input  logic [AW-1:0]     byte_addr_i,
  input  logic [DATA_W-1:0] byte_wdata_i,
  input  logic              bit_we_i,
  input  logic [AW-1:0]     bit_byte_i,
  input  logic [POS_W-1:0]  bit_pos_i,
  input  logic              bit_val_i,
  input  logic [AW-1:0]     reg_addr_i,
  output logic [DATA_W-1:0] byte_rdata_o,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic [DATA_W-1:0] bit_word_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  // Gated bit write first; a byte write to the same entry follows and wins.
  always_ff @(posedge clk) begin
    if (bit_we_i)  mem[bit_byte_i][bit_pos_i] <= bit_val_i;
    if (byte_we_i) mem[byte_addr_i]           <= byte_wdata_i;
  end

  assign byte_rdata_o = mem[byte_addr_i];
  assign reg_rdata_o  = mem[reg_addr_i];
  assign bit_word_o   = mem[bit_byte_i];
endmodule

// File: rtl/iram_banked.sv
module iram_banked #(
  parameter int DATA_W    = 8,
  parameter int DEPTH     = 128,
  parameter int NUM_BANKS = 4,
  parameter int BANK_REGS = 8,
  parameter int BIT_BASE  = 32,
  parameter int BIT_BYTES = 16,
  localparam int AW       = $clog2(DEPTH),
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int IDX_W    = $clog2(BANK_REGS),
  localparam int BIT_AW   = $clog2(BIT_BYTES * DATA_W),
  localparam int POS_W    = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_wr_i,
  input  logic [BANK_W-1:0] bank_sel_i,
  input  logic [AW-1:0]     byte_addr_i,
  input  logic              byte_we_i,
  input  logic [DATA_W-1:0] byte_wdata_i,
  output logic [DATA_W-1:0] byte_rdata_o,
  input  logic [IDX_W-1:0]  reg_idx_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [BIT_AW-1:0] bit_addr_i,
  input  logic              bit_we_i,
  input  logic              bit_val_i,
  output logic              bit_rdata_o
);
  // Named internal events for the checker.
  logic [BANK_W-1:0] bank_q;
  logic [AW-1:0]     reg_addr_w;
  logic [AW-1:0]     bit_byte_w;
  logic [POS_W-1:0]  bit_pos_w;
  logic              bit_clash;
  logic              bit_we_eff;
  logic [DATA_W-1:0] bit_word_w;

  iram_bank #(.BANK_W(BANK_W)) bank_i (
    .clk(clk), .rst_n(rst_n), .load_i(bank_wr_i), .sel_i(bank_sel_i), .bank_o(bank_q)
  );

  iram_map #(
    .AW(AW), .BANK_W(BANK_W), .IDX_W(IDX_W), .BIT_AW(BIT_AW), .POS_W(POS_W),
    .BANK_REGS(BANK_REGS), .BIT_BASE(BIT_BASE), .DATA_W(DATA_W)
  ) map_i (
    .bank_i(bank_q), .idx_i(reg_idx_i), .bit_addr_i(bit_addr_i),
    .reg_addr_o(reg_addr_w), .bit_byte_o(bit_byte_w), .bit_pos_o(bit_pos_w)
  );

  assign bit_clash  = byte_we_i && bit_we_i && (byte_addr_i == bit_byte_w);
  assign bit_we_eff = bit_we_i && !bit_clash;

  iram_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW), .POS_W(POS_W)) store_i (
    .clk(clk),
    .byte_we_i(byte_we_i), .byte_addr_i(byte_addr_i), .byte_wdata_i(byte_wdata_i),
    .bit_we_i(bit_we_eff), .bit_byte_i(bit_byte_w), .bit_pos_i(bit_pos_w),
    .bit_val_i(bit_val_i), .reg_addr_i(reg_addr_w),
    .byte_rdata_o(byte_rdata_o), .reg_rdata_o(reg_rdata_o), .bit_word_o(bit_word_w)
  );

  assign bit_rdata_o = bit_word_w[bit_pos_w];
endmodule

// File: rtl/iram_banked_chk.sv
module iram_banked_chk #(
  parameter int DATA_W = 8,
  parameter int AW     = 7,
  parameter int BANK_W = 2,
  parameter int BIT_AW = 7,
  parameter int POS_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [BANK_W-1:0] bank_q,
  input logic [AW-1:0]     byte_addr_i,
  input logic              byte_we_i,
  input logic [DATA_W-1:0] byte_wdata_i,
  input logic [DATA_W-1:0] byte_rdata_o,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic [AW-1:0]     reg_addr_w,
  input logic [BIT_AW-1:0] bit_addr_i,
  input logic              bit_we_i,
  input logic              bit_val_i,
  input logic              bit_rdata_o,
  input logic [AW-1:0]     bit_byte_w,
  input logic [POS_W-1:0]  bit_pos_w,
  input logic              bit_clash
);
  assert_byte_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    byte_we_i |=> (byte_addr_i != $past(byte_addr_i)) || (byte_rdata_o == $past(byte_wdata_i)));

  assert_reg_view_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_addr_i == reg_addr_w) |-> (reg_rdata_o == byte_rdata_o));

  assert_bank_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (bank_q == '0));

  assert_bit_view_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_addr_i == bit_byte_w) |-> (bit_rdata_o == byte_rdata_o[bit_pos_w]));

  assert_bit_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_we_i && !bit_clash) |=> (bit_addr_i != $past(bit_addr_i)) || (bit_rdata_o == $past(bit_val_i)));

  assert_bit_others_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_we_i && !byte_we_i && byte_addr_i == bit_byte_w) |=>
      (byte_addr_i != $past(byte_addr_i)) ||
      (((byte_rdata_o ^ $past(byte_rdata_o)) & ~(DATA_W'(1) << $past(bit_pos_w))) == '0));

  assert_clash_byte_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bit_clash |=> (byte_addr_i != $past(byte_addr_i)) || (byte_rdata_o == $past(byte_wdata_i)));
endmodule

bind iram_banked iram_banked_chk #(
  .DATA_W(DATA_W), .AW(AW), .BANK_W(BANK_W), .BIT_AW(BIT_AW), .POS_W(POS_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bank_q(bank_q),
  .byte_addr_i(byte_addr_i), .byte_we_i(byte_we_i), .byte_wdata_i(byte_wdata_i),
  .byte_rdata_o(byte_rdata_o), .reg_rdata_o(reg_rdata_o), .reg_addr_w(reg_addr_w),
  .bit_addr_i(bit_addr_i), .bit_we_i(bit_we_i), .bit_val_i(bit_val_i),
  .bit_rdata_o(bit_rdata_o), .bit_byte_w(bit_byte_w), .bit_pos_w(bit_pos_w),
  .bit_clash(bit_clash)
);

// File: tb/iram_banked_tb_top.sv
`timescale 1ns/1ps
module iram_banked_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bank_wr_i = 1'b0;
  logic [1:0] bank_sel_i = '0;
  logic [6:0] byte_addr_i = '0;
  logic       byte_we_i = 1'b0;
  logic [7:0] byte_wdata_i = '0;
  logic [7:0] byte_rdata_o;
  logic [2:0] reg_idx_i = '0;
  logic [7:0] reg_rdata_o;
  logic [6:0] bit_addr_i = '0;
  logic       bit_we_i = 1'b0;
  logic       bit_val_i = 1'b0;
  logic       bit_rdata_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0] mdl [128];
  logic [1:0] bank_m = '0;

  always #2 clk = ~clk;

  iram_banked dut_i (
    .clk(clk), .rst_n(rst_n), .bank_wr_i(bank_wr_i), .bank_sel_i(bank_sel_i),
    .byte_addr_i(byte_addr_i), .byte_we_i(byte_we_i), .byte_wdata_i(byte_wdata_i),
    .byte_rdata_o(byte_rdata_o), .reg_idx_i(reg_idx_i), .reg_rdata_o(reg_rdata_o),
    .bit_addr_i(bit_addr_i), .bit_we_i(bit_we_i), .bit_val_i(bit_val_i),
    .bit_rdata_o(bit_rdata_o)
  );

  // Bench-side restatement of the address maps.
  function automatic logic [6:0] exp_reg_addr(input logic [1:0] b, input logic [2:0] n);
    return {b, n} | 7'h00;
  endfunction
  function automatic logic [6:0] exp_bit_byte(input logic [6:0] k);
    return 7'h20 + {3'b000, k[6:3]};
  endfunction
  function automatic logic exp_bit(input logic [6:0] k);
    logic [7:0] w;
    w = mdl[exp_bit_byte(k)] >> k[2:0];
    return w[0];
  endfunction

  task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // One clock: drive at negedge, check reads, then update the model at posedge.
  task automatic step(input logic bwe, input logic [6:0] ba, input logic [7:0] bd,
                      input logic [2:0] ri, input logic kwe, input logic [6:0] ka,
                      input logic kv, input logic bkwe, input logic [1:0] bk,
                      input bit do_chk);
    logic [6:0] kb;
    @(negedge clk);
    byte_we_i = bwe; byte_addr_i = ba; byte_wdata_i = bd; reg_idx_i = ri;
    bit_we_i = kwe; bit_addr_i = ka; bit_val_i = kv; bank_wr_i = bkwe; bank_sel_i = bk;
    #1;
    if (do_chk) begin
      chk(byte_rdata_o, mdl[ba], "R1 byte read");
      chk(reg_rdata_o, mdl[exp_reg_addr(bank_m, ri)], "R2 register read");
      chk({7'd0, bit_rdata_o}, {7'd0, exp_bit(ka)}, "R5 bit read");
    end
    @(posedge clk);
    kb = exp_bit_byte(ka);
    if (kwe && !(bwe && ba == kb)) mdl[kb][ka[2:0]] = kv;
    if (bwe) mdl[ba] = bd;
    if (bkwe) bank_m = bk;
  endtask

  task automatic idle_read(input logic [6:0] ba, input logic [2:0] ri, input logic [6:0] ka);
    @(negedge clk);
    byte_we_i = 0; bit_we_i = 0; bank_wr_i = 0;
    byte_addr_i = ba; reg_idx_i = ri; bit_addr_i = ka;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired got=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // Fill every byte (R1) with a known pattern.
    for (int a = 0; a < 128; a++)
      step(1'b1, 7'(a), 8'(a * 37 + 5), 3'd0, 1'b0, 7'd0, 1'b0, 1'b0, 2'd0, 1'b0);

    // Reset state: bank 0, R7 is byte 07H (R4, R2).
    idle_read(7'h7F, 3'd7, 7'd0);
    chk(reg_rdata_o, 8'(7 * 37 + 5), "R4 bank 0 after reset");
    chk(byte_rdata_o, 8'(127 * 37 + 5), "R1 scratch top byte 7FH");

    // Bank load is seen the next cycle (R3).
    step(1'b0, 7'd0, 8'd0, 3'd2, 1'b0, 7'd0, 1'b0, 1'b1, 2'd3, 1'b0);
    idle_read(7'd0, 3'd2, 7'd0);
    chk(reg_rdata_o, 8'(26 * 37 + 5), "R3 bank 3 R2 -> byte 1AH");

    // Reset with bank 3 loaded: bank returns to 0, contents kept (R4).
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    bank_m = 2'd0;
    idle_read(7'h1A, 3'd2, 7'd0);
    chk(reg_rdata_o, 8'(2 * 37 + 5), "R4 bank back to 0 after reset");
    chk(byte_rdata_o, 8'(26 * 37 + 5), "R4 contents kept over reset");

    // Bit corners (R5, R6): bit 00H -> 20H.0, bit 7FH -> 2FH.7.
    step(1'b1, 7'h20, 8'hA5, 3'd0, 1'b0, 7'd0, 1'b0, 1'b0, 2'd0, 1'b0);
    step(1'b1, 7'h2F, 8'h00, 3'd0, 1'b0, 7'd0, 1'b0, 1'b0, 2'd0, 1'b0);
    step(1'b0, 7'd0, 8'd0, 3'd0, 1'b1, 7'h00, 1'b0, 1'b0, 2'd0, 1'b0);
    step(1'b0, 7'd0, 8'd0, 3'd0, 1'b1, 7'h7F, 1'b1, 1'b0, 2'd0, 1'b0);
    idle_read(7'h20, 3'd0, 7'h00);
    chk(byte_rdata_o, 8'hA4, "R6 clear bit 00H keeps others");
    chk({7'd0, bit_rdata_o}, 8'd0, "R5 bit 00H read");
    idle_read(7'h2F, 3'd0, 7'h7F);
    chk(byte_rdata_o, 8'h80, "R6 set bit 7FH keeps others");
    chk({7'd0, bit_rdata_o}, 8'd1, "R5 bit 7FH read");

    // Same-byte clash: byte write wins (R7). Bit 2BH -> byte 25H bit 3.
    step(1'b1, 7'h25, 8'h00, 3'd0, 1'b1, 7'h2B, 1'b1, 1'b0, 2'd0, 1'b0);
    idle_read(7'h25, 3'd0, 7'h2B);
    chk(byte_rdata_o, 8'h00, "R7 byte write wins clash");

    // Different bytes in one cycle: both land (R8). Bit 31H -> byte 26H bit 1.
    step(1'b1, 7'h40, 8'h3C, 3'd0, 1'b0, 7'd0, 1'b0, 1'b0, 2'd0, 1'b0);
    step(1'b1, 7'h26, 8'h00, 3'd0, 1'b0, 7'd0, 1'b0, 1'b0, 2'd0, 1'b0);
    step(1'b1, 7'h40, 8'hC3, 3'd0, 1'b1, 7'h31, 1'b1, 1'b0, 2'd0, 1'b0);
    idle_read(7'h40, 3'd0, 7'h31);
    chk(byte_rdata_o, 8'hC3, "R8 byte write beside bit write");
    chk({7'd0, bit_rdata_o}, 8'd1, "R8 bit write beside byte write");

    // Seeded random mix with biased clashes.
    for (int i = 0; i < 3000; i++) begin
      logic [6:0] ka, ba;
      ka = 7'($urandom);
      ba = (($urandom % 4) == 0) ? exp_bit_byte(ka) : 7'($urandom);
      step(($urandom % 3) == 0, ba, 8'($urandom), 3'($urandom),
           ($urandom % 2) == 0, ka, 1'($urandom),
           ($urandom % 8) == 0, 2'($urandom), 1'b1);
    end
    idle_read(7'd0, 3'd0, 7'd0);
    chk(byte_rdata_o, mdl[0], "R1 final byte 00H");
    finish_run();
  end
endmodule